// File: doc/BRIEF.md
# Mode-Banked General Register File

This block stores the fifteen 32-bit general registers of a processor core that runs in one of several privilege modes. A 5-bit mode input picks which register view the read port and the write port see. Most indices land on storage that every mode shares. A few indices land on copies that belong to one mode alone. The fast-interrupt view has its own copies of the upper seven indices. The interrupt, supervisor, abort and undefined views each have their own copy of only the top two indices. System mode sees the same storage as user mode.

Each mode that is entered by an exception also has a saved status word. A separate status port reads and writes it. For user and system mode there is no saved status word, and the block raises a status error. A mode value outside the seven defined encodings raises a mode error. While that error is high, both write ports are blocked and both reads return zero.

Writes take effect at the rising clock edge. Reads are combinational from the current mode and index, so a value written in one cycle can be read in the next.

Top module: `bank_rf`

## Requirements
- R1: After the asynchronous active-low reset, every general register and every saved status word reads zero in every mode.
- R2: A write with `wr_en_i` high stores `wr_data_i` at the rising edge. The read port is combinational, so the stored value is visible in the following cycle at the same mode and index.
- R3: System mode (5'b11111) reads and writes exactly the same storage as user mode (5'b10000) for indices 0 to 14.
- R4: In fast-interrupt mode (5'b10001), indices 8 to 14 use storage private to that mode. Indices 0 to 7 are shared with the user view.
- R5: In interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes, indices 13 and 14 use storage private to each mode. Indices 0 to 12 are shared with the user view.
- R6: The fast-interrupt, interrupt, supervisor, abort and undefined modes each own one independent saved status word. In those modes `sts_err_o` is low, and the status port reads and writes that mode's word.
- R7: In user and system mode, `sts_err_o` is high, the status read returns zero, and a status write changes no saved status word.
- R8: Only the seven encodings named in R3 to R5 are legal. Any other mode value drives `mode_err_o` high.
- R9: While `mode_err_o` is high, `sts_err_o` is also high, both reads return zero, and neither write port changes any storage.
- R10: Register index 15 has no storage. Reads of it return zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current processor mode |
| rd_idx_i | input | 4 | Register index for the read port |
| rd_data_o | output | 32 | Read data, combinational |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Register index for the write port |
| wr_data_i | input | 32 | Write data |
| sts_rd_data_o | output | 32 | Saved status word of the current mode |
| sts_wr_en_i | input | 1 | Saved status write enable |
| sts_wr_data_i | input | 32 | Saved status write data |
| mode_err_o | output | 1 | Mode value is not a legal encoding |
| sts_err_o | output | 1 | Current mode has no saved status word |

## Verification
The bench first fills the shared registers, then writes the banked indices from each privileged view, then reads them back across views. A mapper that banks one index too many or one too few would show a fast-interrupt value leaking into the user view at index 7 or 8, or an interrupt-mode value leaking at index 12 or 13. The bench writes in system mode and reads in user mode, so a design that gave system mode its own bank would return stale data. Write attempts with illegal mode values, with index 15, and to the status port in user and system mode are each followed by reads of every location they could have reached. A design that let any of them through would show changed data. A random phase mixes all views, the illegal encodings and both ports, and compares every cycle against a model keyed by view name.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  localparam int NUM_BANKS     = 6;
  localparam int NUM_STS_BANKS = NUM_BANKS - 1;
  localparam int NUM_PRIV2     = NUM_BANKS - 2;  // modes banking only the top indices

  typedef struct packed {
    bank_e bank;
    logic  legal;
    logic  has_sts;
  } mode_info_t;

endpackage

// File: rtl/bank_rf_mode_dec.sv
module bank_rf_mode_dec
  import bank_rf_pkg::*;
(
  input  logic [4:0] mode_i,
  output mode_info_t info_o
);

  always_comb begin
    info_o.bank    = BANK_USR;
    info_o.legal   = 1'b1;
    info_o.has_sts = 1'b1;
    unique case (mode_i)
      // low four views: bank index is the mode with bit 4 cleared
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC:
        info_o.bank = bank_e'({1'b0, mode_i[1:0]});
      MODE_ABT: info_o.bank = BANK_ABT;
      MODE_UND: info_o.bank = BANK_UND;
      MODE_SYS: info_o.bank = BANK_USR;
      default: begin
        info_o.legal   = 1'b0;
        info_o.has_sts = 1'b0;
      end
    endcase
    if (info_o.bank == BANK_USR) info_o.has_sts = 1'b0;
  end

endmodule

// File: rtl/bank_rf_slot_map.sv
module bank_rf_slot_map
  import bank_rf_pkg::*;
#(
  parameter int NUM_REGS   = 15,
  parameter int FIQ_FIRST  = 8,
  parameter int PRIV_FIRST = 13,
  parameter int IW         = 4,
  parameter int SW         = 5
) (
  input  mode_info_t    info_i,
  input  logic [IW-1:0] idx_i,
  output logic [SW-1:0] slot_o,
  output logic          valid_o
);

  localparam int FIQ_BASE  = NUM_REGS;
  localparam int FIQ_CNT   = NUM_REGS - FIQ_FIRST;
  localparam int PRIV_BASE = FIQ_BASE + FIQ_CNT;
  localparam int PRIV_CNT  = NUM_REGS - PRIV_FIRST;

  int idx;
  int slot;

  always_comb begin
    idx  = int'(idx_i);
    slot = idx;
    if (info_i.bank == BANK_FIQ && idx >= FIQ_FIRST)
      slot = FIQ_BASE + (idx - FIQ_FIRST);
    else if (info_i.bank != BANK_USR && info_i.bank != BANK_FIQ && idx >= PRIV_FIRST)
      slot = PRIV_BASE + (int'(info_i.bank) - int'(BANK_IRQ)) * PRIV_CNT + (idx - PRIV_FIRST);
    valid_o = info_i.legal && (idx < NUM_REGS);
    slot_o  = valid_o ? SW'(slot) : '0;
  end

endmodule

// File: rtl/bank_rf_store.sv
module bank_rf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 30,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && int'(waddr_i) < DEPTH) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;

endmodule

// File: rtl/bank_rf.sv
module bank_rf
  import bank_rf_pkg::*;
#(
  parameter  int DW         = 32,
  parameter  int NUM_REGS   = 15,
  parameter  int FIQ_FIRST  = 8,
  parameter  int PRIV_FIRST = 13,
  localparam int IW         = $clog2(NUM_REGS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    mode_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] sts_rd_data_o,
  input  logic          sts_wr_en_i,
  input  logic [DW-1:0] sts_wr_data_i,
  output logic          mode_err_o,
  output logic          sts_err_o
);

  localparam int NUM_SLOTS = NUM_REGS + (NUM_REGS - FIQ_FIRST)
                           + NUM_PRIV2 * (NUM_REGS - PRIV_FIRST);
  localparam int SW  = $clog2(NUM_SLOTS);
  localparam int STW = $clog2(NUM_STS_BANKS);

  mode_info_t    info;
  logic [SW-1:0] rd_slot, wr_slot;
  logic          rd_valid, wr_valid;
  logic [DW-1:0] gpr_rdata, sts_rdata;
  logic [STW-1:0] sts_slot;

  bank_rf_mode_dec u_dec (
    .mode_i (mode_i),
    .info_o (info)
  );

  bank_rf_slot_map #(
    .NUM_REGS(NUM_REGS), .FIQ_FIRST(FIQ_FIRST), .PRIV_FIRST(PRIV_FIRST), .IW(IW), .SW(SW)
  ) u_rd_map (
    .info_i (info),
    .idx_i  (rd_idx_i),
    .slot_o (rd_slot),
    .valid_o(rd_valid)
  );

  bank_rf_slot_map #(
    .NUM_REGS(NUM_REGS), .FIQ_FIRST(FIQ_FIRST), .PRIV_FIRST(PRIV_FIRST), .IW(IW), .SW(SW)
  ) u_wr_map (
    .info_i (info),
    .idx_i  (wr_idx_i),
    .slot_o (wr_slot),
    .valid_o(wr_valid)
  );

  bank_rf_store #(.DW(DW), .DEPTH(NUM_SLOTS), .AW(SW)) u_gpr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i && wr_valid),
    .waddr_i(wr_slot),
    .wdata_i(wr_data_i),
    .raddr_i(rd_slot),
    .rdata_o(gpr_rdata)
  );

  // saved status slots start at the fast-interrupt bank
  assign sts_slot = info.has_sts ? STW'(int'(info.bank) - int'(BANK_FIQ)) : '0;

  bank_rf_store #(.DW(DW), .DEPTH(NUM_STS_BANKS), .AW(STW)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sts_wr_en_i && info.has_sts),
    .waddr_i(sts_slot),
    .wdata_i(sts_wr_data_i),
    .raddr_i(sts_slot),
    .rdata_o(sts_rdata)
  );

  assign rd_data_o     = rd_valid ? gpr_rdata : '0;
  assign sts_rd_data_o = info.has_sts ? sts_rdata : '0;
  assign mode_err_o    = ~info.legal;
  assign sts_err_o     = ~info.has_sts;

endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk #(
  parameter int DW       = 32,
  parameter int NUM_REGS = 15,
  parameter int IW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    mode_i,
  input logic [IW-1:0] rd_idx_i,
  input logic [DW-1:0] rd_data_o,
  input logic          wr_en_i,
  input logic [IW-1:0] wr_idx_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] sts_rd_data_o,
  input logic          sts_wr_en_i,
  input logic [DW-1:0] sts_wr_data_i,
  input logic          mode_err_o,
  input logic          sts_err_o
);

  p_wr_then_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_err_o && int'(wr_idx_i) < NUM_REGS && wr_idx_i == rd_idx_i)
    |=> (($stable(mode_i) && $stable(rd_idx_i)) -> rd_data_o == $past(wr_data_i)));

  p_sts_wr_then_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_en_i && !sts_err_o)
    |=> ($stable(mode_i) -> sts_rd_data_o == $past(sts_wr_data_i)));

  p_no_sts_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_err_o |-> sts_rd_data_o == '0);

  p_illegal_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> (sts_err_o && rd_data_o == '0));

  p_idx15_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_idx_i) >= NUM_REGS) |-> rd_data_o == '0);

  p_legal_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !(mode_i inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                    5'b10111, 5'b11011, 5'b11111}));

endmodule

bind bank_rf bank_rf_chk #(.DW(DW), .NUM_REGS(NUM_REGS), .IW(IW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .rd_idx_i     (rd_idx_i),
  .rd_data_o    (rd_data_o),
  .wr_en_i      (wr_en_i),
  .wr_idx_i     (wr_idx_i),
  .wr_data_i    (wr_data_i),
  .sts_rd_data_o(sts_rd_data_o),
  .sts_wr_en_i  (sts_wr_en_i),
  .sts_wr_data_i(sts_wr_data_i),
  .mode_err_o   (mode_err_o),
  .sts_err_o    (sts_err_o)
);

// File: tb/bank_rf_bench.sv
module bank_rf_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] sts_rd_data_o;
  logic        sts_wr_en_i = 1'b0;
  logic [31:0] sts_wr_data_i = '0;
  logic        mode_err_o, sts_err_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] gmodel [string];
  logic [31:0] smodel [string];

  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_rf u_bank_rf (.*);

  function automatic bit legal(logic [4:0] m);
    return m inside {M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
  endfunction

  // storage location name for a view and index, "" when none
  function automatic string gkey(logic [4:0] m, int i);
    if (!legal(m) || i > 14) return "";
    case (m)
      M_FIQ: return (i >= 8) ? $sformatf("fiq%0d", i) : $sformatf("usr%0d", i);
      M_IRQ: return (i >= 13) ? $sformatf("irq%0d", i) : $sformatf("usr%0d", i);
      M_SVC: return (i >= 13) ? $sformatf("svc%0d", i) : $sformatf("usr%0d", i);
      M_ABT: return (i >= 13) ? $sformatf("abt%0d", i) : $sformatf("usr%0d", i);
      M_UND: return (i >= 13) ? $sformatf("und%0d", i) : $sformatf("usr%0d", i);
      default: return $sformatf("usr%0d", i);
    endcase
  endfunction

  function automatic string skey(logic [4:0] m);
    case (m)
      M_FIQ: return "fiq";
      M_IRQ: return "irq";
      M_SVC: return "svc";
      M_ABT: return "abt";
      M_UND: return "und";
      default: return "";
    endcase
  endfunction

  function automatic logic [31:0] gexp(logic [4:0] m, int i);
    string k = gkey(m, i);
    if (k == "" || !gmodel.exists(k)) return 32'd0;
    return gmodel[k];
  endfunction

  function automatic logic [31:0] sexp(logic [4:0] m);
    string k = skey(m);
    if (k == "" || !smodel.exists(k)) return 32'd0;
    return smodel[k];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive after negedge, check combinational outputs, update model at posedge
  task automatic step(string tag, logic [4:0] m, int ri, bit we, int wi, logic [31:0] wd,
                      bit swe, logic [31:0] sd);
    mode_i = m; rd_idx_i = 4'(ri); wr_en_i = we; wr_idx_i = 4'(wi); wr_data_i = wd;
    sts_wr_en_i = swe; sts_wr_data_i = sd;
    #1;
    chk(tag, $sformatf("rd m=%b i=%0d", m, ri), rd_data_o, gexp(m, ri));
    chk(tag, $sformatf("sts m=%b", m), sts_rd_data_o, sexp(m));
    chk(tag, "mode_err", {31'd0, mode_err_o}, {31'd0, !legal(m)});
    chk(tag, "sts_err", {31'd0, sts_err_o}, {31'd0, skey(m) == ""});
    @(posedge clk_i);
    if (we && gkey(m, wi) != "") gmodel[gkey(m, wi)] = wd;
    if (swe && skey(m) != "") smodel[skey(m)] = sd;
    @(negedge clk_i);
  endtask

  task automatic rd(string tag, logic [4:0] m, int i);
    step(tag, m, i, 0, 0, 0, 0, 0);
  endtask

  task automatic sweep(string tag, logic [4:0] m);
    for (int i = 0; i < 16; i++) rd(tag, m, i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
    logic [4:0] bad [4] = '{5'b00000, 5'b10100, 5'b11010, 5'b01111};
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: everything zero after reset
    foreach (modes[k]) sweep("R1", modes[k]);

    // R2: fill user view, read back
    for (int i = 0; i < 15; i++) step("R2", M_USR, 0, 1, i, 32'h1000_0000 + i, 0, 0);
    sweep("R2", M_USR);

    // R3: system view aliases user view
    sweep("R3", M_SYS);
    step("R3", M_SYS, 0, 1, 14, 32'h5151_0014, 0, 0);
    step("R3", M_SYS, 0, 1, 3, 32'h5151_0003, 0, 0);
    rd("R3", M_USR, 14);
    rd("R3", M_USR, 3);

    // R4: fast-interrupt bank for 8..14
    for (int i = 0; i < 15; i++) step("R4", M_FIQ, i, 1, i, 32'hF000_0000 + i, 0, 0);
    sweep("R4", M_FIQ);
    sweep("R4", M_USR);

    // R5: top two indices per privileged view, index 12 shared
    for (int k = 2; k < 6; k++) begin
      step("R5", modes[k], 0, 1, 13, {modes[k], 27'h13}, 0, 0);
      step("R5", modes[k], 0, 1, 14, {modes[k], 27'h14}, 0, 0);
      step("R5", modes[k], 13, 1, 12, {modes[k], 27'h12}, 0, 0);
    end
    foreach (modes[k]) sweep("R5", modes[k]);

    // R6: saved status per view
    for (int k = 1; k < 6; k++) step("R6", modes[k], 0, 0, 0, 0, 1, 32'hC0DE_0000 + k);
    for (int k = 1; k < 6; k++) rd("R6", modes[k], 0);

    // R7: no saved status in user/system
    step("R7", M_USR, 0, 0, 0, 0, 1, 32'hDEAD_0001);
    step("R7", M_SYS, 0, 0, 0, 0, 1, 32'hDEAD_0002);
    foreach (modes[k]) rd("R7", modes[k], 0);

    // R8/R9: illegal encodings raise error, block writes
    foreach (bad[b]) begin
      step("R8", bad[b], 5, 1, 5, 32'hBAD0_0005, 1, 32'hBAD0_5555);
      step("R9", bad[b], 13, 1, 13, 32'hBAD0_0013, 1, 32'hBAD0_1313);
    end
    foreach (modes[k]) sweep("R9", modes[k]);

    // R10: index 15 has no storage
    foreach (modes[k]) step("R10", modes[k], 15, 1, 15, 32'hFFFF_0015, 0, 0);
    foreach (modes[k]) sweep("R10", modes[k]);

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int pick = $urandom_range(0, 9);
      logic [4:0] m = (pick < 7) ? modes[pick] : 5'($urandom);
      step("R2", m, $urandom_range(0, 15), 1'($urandom), $urandom_range(0, 15), $urandom,
           1'($urandom), $urandom);
    end
    foreach (modes[k]) sweep("R2", modes[k]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule